// File: doc/BRIEF.md
# Complementary Burst Pulse Sequencer

This block drives the low-voltage control lines of an ultrasonic transmit stage. A start request carrying a cycle count launches one framed burst. An enable envelope rises first. A train of complementary half-cycles follows on a positive and a negative drive leg. A dump pulse discharges the transducer after the last cycle. A short trailing margin then closes the envelope. Each clock of the block is one tick of the 16 MHz timing reference, so every phase length is a whole number of ticks.

The drive frequency is set by writing a frequency in hertz. The block derives the full-period tick count by integer division of the tick rate, and uses half of that count for the positive half-cycle. All four control lines leave the block inside a wider output port word. The remaining bits of that word carry host-supplied values, such as transducer channel selects, and the sequencer never alters them. While a burst runs, the block reports busy and ignores further start requests.

Top module: `burst_pulse_seq`

## Requirements
- R1: A synchronous reset drives the whole output word to zero, clears busy and restores the default period of 8 ticks with a half-period of 4 ticks.
- R2: The requested cycle count is limited to 1..20 when the burst is accepted: a count of 0 produces one cycle and any count above 20 produces twenty.
- R3: After the clock edge that accepts a start, enable alone is high, with both drive legs and dump low, for LEAD_TICKS ticks (default 2).
- R4: Each drive cycle shows positive high and negative low for the half-period, then positive low and negative high for the full period minus the half-period. The two legs are never high together.
- R5: On the edge where the last negative half-cycle ends, dump rises with enable high and both legs low, and it stays high for DUMP_TICKS ticks (default 8).
- R6: After dump falls, enable alone stays high for TRAIL_TICKS ticks (default 2). All four control bits then return to zero.
- R7: Busy is high from the edge that accepts a start until the edge that returns the control bits to zero. A start sampled while busy is high, including in the last trailing tick, is ignored.
- R8: A frequency write between 100000 and 4000000 Hz inclusive sets the period to floor(16000000 / f) ticks and the half-period to floor(period / 2). A write outside that range leaves both unchanged.
- R9: A burst uses the period that was in force on the edge that accepted it. A frequency write during the burst, or on that same edge, affects only later bursts.
- R10: Every bit of the output word other than the four control bits equals the corresponding bit of the pass-through input sampled on the previous clock edge, in every phase.
- R11: In the output word, enable is bit 4, positive drive is bit 5, negative drive is bit 6 and dump is bit 7 (default 12-bit word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per 62.5 ns reference tick |
| rst | input | 1 | Synchronous reset, active high |
| freq_wr | input | 1 | Strobe to load a new drive frequency |
| freq_hz | input | 32 | Requested drive frequency in hertz |
| start | input | 1 | Burst request, honoured only while idle |
| cycles | input | 8 | Requested number of drive cycles |
| keep_in | input | 12 | Host values for the non-control bits of the port word |
| port_out | output | 12 | Registered port word: control bits merged with pass-through bits |
| busy | output | 1 | High while a burst sequence is in progress |

## Verification
Two collisions are provoked on purpose. In the first, start is held high across the end of a burst, so a request lands in the last trailing tick, where it must be rejected, and again one tick later, where it must launch a fresh burst. In the second, a frequency write is issued on the same edge as an accepted start, so the period register changes while the burst latches its copy. The burst must still run at the old period, and only the following burst may show the new one. A behavioural model in the bench predicts the full control word, busy and pass-through bits on every tick and compares them in both situations.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_DUMP,
    PH_TRAIL
  } phase_t;

  // Limit a requested count to [lo, hi].
  function automatic int unsigned clamp_count(input int unsigned req,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // True when a frequency request is inside the accepted window.
  function automatic logic freq_in_range(input logic [31:0] f,
                                         input logic [31:0] lo,
                                         input logic [31:0] hi);
    return (f >= lo) && (f <= hi);
  endfunction

  // Whole reference ticks in one period of frequency f.
  function automatic logic [31:0] ticks_of(input logic [31:0] tick_hz,
                                           input logic [31:0] f);
    if (f == 32'd0) return 32'd0;
    return tick_hz / f;
  endfunction

endpackage

// File: rtl/bps_period_reg.sv
module bps_period_reg
  import burst_seq_pkg::*;
#(
  parameter int TICK_HZ = 16_000_000,
  parameter int MIN_HZ  = 100_000,
  parameter int MAX_HZ  = 4_000_000,
  parameter int DEF_PER = 8,
  parameter int PER_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freq_wr,
  input  logic [31:0]       freq_hz,
  output logic [PER_W-1:0]  per_q,
  output logic [PER_W-1:0]  half_q
);

  localparam logic [PER_W-1:0] DEF_P   = PER_W'(DEF_PER);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(TICK_HZ / MAX_HZ);
  localparam logic [PER_W-1:0] MAX_PER = PER_W'(TICK_HZ / MIN_HZ);

  logic             freq_ok;
  logic [PER_W-1:0] per_new;

  assign freq_ok = freq_in_range(freq_hz, 32'(MIN_HZ), 32'(MAX_HZ));
  assign per_new = PER_W'(ticks_of(32'(TICK_HZ), freq_hz));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= DEF_P;
      half_q <= DEF_P >> 1;
    end else if (freq_wr && freq_ok) begin
      per_q  <= per_new;
      half_q <= per_new >> 1;
    end
  end

  // R8: out-of-range writes leave the setting untouched
  a_r8_reject_hold: assert property (@(posedge clk) disable iff (rst)
    (freq_wr && !freq_ok) |=> ($stable(per_q) && $stable(half_q)));

  // R8: the period always stays inside the legal tick window
  a_r8_period_window: assert property (@(posedge clk) disable iff (rst)
    (per_q >= MIN_PER) && (per_q <= MAX_PER));

endmodule

// File: rtl/bps_phase_ctrl.sv
module bps_phase_ctrl
  import burst_seq_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int CYC_W       = 8,
  parameter int REM_W       = 5,
  parameter int LEAD_TICKS  = 2,
  parameter int DUMP_TICKS  = 8,
  parameter int TRAIL_TICKS = 2,
  parameter int MIN_CYC     = 1,
  parameter int MAX_CYC     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CYC_W-1:0]  cycles,
  input  logic [PER_W-1:0]  cfg_per,
  input  logic [PER_W-1:0]  cfg_half,
  output phase_t            phase_q,
  output phase_t            phase_d,
  output logic              busy
);

  localparam logic [PER_W-1:0] LEAD_RL  = PER_W'(LEAD_TICKS - 1);
  localparam logic [PER_W-1:0] DUMP_RL  = PER_W'(DUMP_TICKS - 1);
  localparam logic [PER_W-1:0] TRAIL_RL = PER_W'(TRAIL_TICKS - 1);
  localparam logic [PER_W-1:0] ONE_T    = PER_W'(1);
  localparam logic [REM_W-1:0] ONE_R    = REM_W'(1);
  localparam logic [REM_W-1:0] MAX_R    = REM_W'(MAX_CYC);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [PER_W-1:0] act_per, act_half;

  // named internal events
  logic start_acc;
  logic phase_end;
  logic burst_done;
  logic last_cycle;

  assign start_acc  = start && (phase_q == PH_IDLE);
  assign phase_end  = (cnt_q == '0);
  assign last_cycle = (rem_q == ONE_R);
  assign burst_done = (phase_q == PH_TRAIL) && phase_end;
  assign busy       = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    rem_d   = rem_q;
    cnt_d   = phase_end ? cnt_q : cnt_q - ONE_T;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_acc) begin
          phase_d = PH_LEAD;
          cnt_d   = LEAD_RL;
          rem_d   = REM_W'(clamp_count(32'(cycles), MIN_CYC, MAX_CYC));
        end
      end
      PH_LEAD: if (phase_end) begin
        phase_d = PH_HIGH;
        cnt_d   = act_half - ONE_T;
      end
      PH_HIGH: if (phase_end) begin
        phase_d = PH_LOW;
        cnt_d   = act_per - act_half - ONE_T;
      end
      PH_LOW: if (phase_end) begin
        rem_d = rem_q - ONE_R;
        if (last_cycle) begin
          phase_d = PH_DUMP;
          cnt_d   = DUMP_RL;
        end else begin
          phase_d = PH_HIGH;
          cnt_d   = act_half - ONE_T;
        end
      end
      PH_DUMP: if (phase_end) begin
        phase_d = PH_TRAIL;
        cnt_d   = TRAIL_RL;
      end
      PH_TRAIL: if (phase_end) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        rem_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      rem_q    <= '0;
      act_per  <= '0;
      act_half <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      if (start_acc) begin
        act_per  <= cfg_per;
        act_half <= cfg_half;
      end
    end
  end

  // R2: remaining-cycle counter never exceeds the upper limit
  a_r2_rem_bounded: assert property (@(posedge clk) disable iff (rst)
    rem_q <= MAX_R);

  // R5: the dump phase is entered only from a negative half-cycle
  a_r5_dump_after_low: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DUMP && $past(phase_q) != PH_DUMP) |-> $past(phase_q) == PH_LOW);

  // R7: busy holds until the trailing margin completes
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    (busy && !burst_done) |=> busy);

  // R9: burst timing copy is frozen while a burst runs
  a_r9_active_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(act_per) && $stable(act_half)));

endmodule

// File: rtl/bps_port_merge.sv
module bps_port_merge
  import burst_seq_pkg::*;
#(
  parameter int PORT_W  = 12,
  parameter int PE_BIT  = 4,
  parameter int P_BIT   = 5,
  parameter int N_BIT   = 6,
  parameter int DMP_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_d,
  input  logic [PORT_W-1:0] keep_in,
  output logic [PORT_W-1:0] port_q
);

  localparam logic [PORT_W-1:0] CTRL_MASK =
      (PORT_W'(1) << PE_BIT) | (PORT_W'(1) << P_BIT) |
      (PORT_W'(1) << N_BIT)  | (PORT_W'(1) << DMP_BIT);

  logic [PORT_W-1:0] word;

  always_comb begin
    word          = keep_in;
    word[PE_BIT]  = (phase_d != PH_IDLE);
    word[P_BIT]   = (phase_d == PH_HIGH);
    word[N_BIT]   = (phase_d == PH_LOW);
    word[DMP_BIT] = (phase_d == PH_DUMP);
  end

  always_ff @(posedge clk) begin
    if (rst) port_q <= '0;
    else     port_q <= word;
  end

  // R4: the two drive legs are never high together
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(port_q[P_BIT] && port_q[N_BIT]));

  // R5: dump is only ever driven inside the enable envelope with both legs low
  a_r5_dump_clean: assert property (@(posedge clk) disable iff (rst)
    port_q[DMP_BIT] |-> (port_q[PE_BIT] && !port_q[P_BIT] && !port_q[N_BIT]));

  // R10: non-control bits follow the host value of the previous edge
  a_r10_passthru: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((port_q ^ $past(keep_in)) & ~CTRL_MASK) == '0));

endmodule

// File: rtl/burst_pulse_seq.sv
module burst_pulse_seq
  import burst_seq_pkg::*;
#(
  parameter int PORT_W      = 12,
  parameter int PE_BIT      = 4,
  parameter int P_BIT       = 5,
  parameter int N_BIT       = 6,
  parameter int DMP_BIT     = 7,
  parameter int TICK_HZ     = 16_000_000,
  parameter int MIN_HZ      = 100_000,
  parameter int MAX_HZ      = 4_000_000,
  parameter int DEF_PER     = 8,
  parameter int LEAD_TICKS  = 2,
  parameter int DUMP_TICKS  = 8,
  parameter int TRAIL_TICKS = 2,
  parameter int MIN_CYC     = 1,
  parameter int MAX_CYC     = 20,
  parameter int CYC_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freq_wr,
  input  logic [31:0]       freq_hz,
  input  logic              start,
  input  logic [CYC_W-1:0]  cycles,
  input  logic [PORT_W-1:0] keep_in,
  output logic [PORT_W-1:0] port_out,
  output logic              busy
);

  localparam int PER_W = $clog2(TICK_HZ / MIN_HZ + 1);
  localparam int REM_W = $clog2(MAX_CYC + 1);

  logic [PER_W-1:0] cfg_per, cfg_half;
  phase_t           phase_q, phase_d;

  bps_period_reg #(
    .TICK_HZ(TICK_HZ), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ),
    .DEF_PER(DEF_PER), .PER_W(PER_W)
  ) u_period (
    .clk(clk), .rst(rst), .freq_wr(freq_wr), .freq_hz(freq_hz),
    .per_q(cfg_per), .half_q(cfg_half)
  );

  bps_phase_ctrl #(
    .PER_W(PER_W), .CYC_W(CYC_W), .REM_W(REM_W),
    .LEAD_TICKS(LEAD_TICKS), .DUMP_TICKS(DUMP_TICKS), .TRAIL_TICKS(TRAIL_TICKS),
    .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)
  ) u_phase (
    .clk(clk), .rst(rst), .start(start), .cycles(cycles),
    .cfg_per(cfg_per), .cfg_half(cfg_half),
    .phase_q(phase_q), .phase_d(phase_d), .busy(busy)
  );

  bps_port_merge #(
    .PORT_W(PORT_W), .PE_BIT(PE_BIT), .P_BIT(P_BIT),
    .N_BIT(N_BIT), .DMP_BIT(DMP_BIT)
  ) u_merge (
    .clk(clk), .rst(rst), .phase_d(phase_d), .keep_in(keep_in),
    .port_q(port_out)
  );

  // R3: the first tick of every burst is enable alone
  a_r3_lead_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (port_out[PE_BIT] && !port_out[P_BIT] &&
                     !port_out[N_BIT] && !port_out[DMP_BIT]));

  // R6 / R7: with busy low every control bit is low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(port_out[PE_BIT] || port_out[P_BIT] ||
                port_out[N_BIT] || port_out[DMP_BIT]));

  // R7: enable tracks busy tick for tick
  a_r7_envelope_is_busy: assert property (@(posedge clk) disable iff (rst)
    busy == port_out[PE_BIT]);

endmodule

// File: tb/sim_burst_pulse_seq.sv
module sim_burst_pulse_seq;

  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          freq_wr = 1'b0;
  logic [31:0]   freq_hz = 32'd0;
  logic          start = 1'b0;
  logic [7:0]    cycles = 8'd0;
  logic [PW-1:0] keep_in = '0;
  logic [PW-1:0] port_out;
  logic          busy;

  int    n_chk = 0;
  int    n_err = 0;
  string scen  = "R1 reset";

  // reference model state; control word bits: 0 enable, 1 pos, 2 neg, 3 dump
  int         m_per  = 8;
  int         m_half = 4;
  int         q[$];
  int         cur    = 0;
  int         last_n = 0;
  logic [PW-1:0] exp_keep = '0;
  bit         started = 1'b0;

  // pulse counter for per-burst cycle check
  int  p_rises = 0;
  bit  prev_p  = 1'b0;
  bit  prev_b  = 1'b0;

  always #5 clk = ~clk;

  burst_pulse_seq u0 (
    .clk(clk), .rst(rst), .freq_wr(freq_wr), .freq_hz(freq_hz),
    .start(start), .cycles(cycles), .keep_in(keep_in),
    .port_out(port_out), .busy(busy)
  );

  function automatic int lim(input int n);
    if (n < 1) return 1;
    if (n > 20) return 20;
    return n;
  endfunction

  // behavioural model advanced on every rising edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      q.delete();
      cur = 0;
      m_per = 8;
      m_half = 4;
      exp_keep = '0;
    end else begin
      if (cur == 0 && start) begin
        last_n = lim(int'(cycles));
        repeat (2) q.push_back(1);
        for (int k = 0; k < last_n; k++) begin
          repeat (m_half) q.push_back(3);
          repeat (m_per - m_half) q.push_back(5);
        end
        repeat (8) q.push_back(9);
        repeat (2) q.push_back(1);
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = 0;
      if (freq_wr && freq_hz >= 100000 && freq_hz <= 4000000) begin
        m_per  = 16000000 / int'(freq_hz);
        m_half = m_per / 2;
      end
      exp_keep = keep_in;
    end
  end

  // random pass-through traffic on every falling edge (R10)
  always @(negedge clk) keep_in <= PW'($urandom);

  // per-tick comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [3:0] act;
      logic [PW-1:0] msk;
      act = {port_out[7], port_out[6], port_out[5], port_out[4]};
      msk = ~(PW'(8'hF0));
      n_chk++;
      if (act !== 4'(cur)) begin
        n_err++;
        $display("FAIL %s (R11 ctrl bits) act=%b exp=%b t=%0t", scen, act, 4'(cur), $time);
      end
      n_chk++;
      if (busy !== (cur != 0)) begin
        n_err++;
        $display("FAIL %s (R7 busy) act=%b exp=%b t=%0t", scen, busy, (cur != 0), $time);
      end
      n_chk++;
      if ((port_out & msk) !== (exp_keep & msk)) begin
        n_err++;
        $display("FAIL R10 pass bits act=%h exp=%h t=%0t", port_out & msk, exp_keep & msk, $time);
      end
      // R2: positive pulses counted over a whole burst
      if (busy && !prev_b) p_rises = 0;
      if (port_out[5] && !prev_p) p_rises++;
      if (!busy && prev_b) begin
        n_chk++;
        if (p_rises != last_n) begin
          n_err++;
          $display("FAIL R2 %s pulse count act=%0d exp=%0d", scen, p_rises, last_n);
        end
      end
      prev_p = port_out[5];
      prev_b = busy;
    end
  end

  task automatic do_start(input int n);
    @(negedge clk);
    start  = 1'b1;
    cycles = 8'(n);
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic set_freq(input int f);
    @(negedge clk);
    freq_wr = 1'b1;
    freq_hz = 32'(f);
    @(negedge clk);
    freq_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired in %s act=running exp=done", scen);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (port_out !== '0 || busy !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset act=%h/%b exp=0/0", port_out, busy);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);

    scen = "R3 R4 R5 R6 default burst of 3";
    do_start(3);
    wait_idle();

    scen = "R2 count 0 limited to 1";
    do_start(0);
    wait_idle();

    scen = "R2 count 25 limited to 20";
    do_start(25);
    wait_idle();

    scen = "R7 starts while busy are ignored";
    do_start(2);
    repeat (5) @(negedge clk);
    do_start(7);
    repeat (20) @(negedge clk);
    do_start(1);
    wait_idle();

    scen = "R7 start held across burst end";
    @(negedge clk);
    start  = 1'b1;
    cycles = 8'd2;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    scen = "R8 3 MHz odd period";
    set_freq(3_000_000);
    do_start(4);
    wait_idle();

    scen = "R8 4 MHz shortest period";
    set_freq(4_000_000);
    do_start(5);
    wait_idle();

    scen = "R8 100 kHz longest period";
    set_freq(100_000);
    do_start(1);
    wait_idle();

    scen = "R8 out-of-range writes ignored";
    set_freq(99_999);
    set_freq(4_000_001);
    set_freq(0);
    do_start(2);
    wait_idle();

    scen = "R9 write during burst";
    set_freq(2_000_000);
    do_start(3);
    repeat (4) @(negedge clk);
    set_freq(1_000_000);
    wait_idle();
    do_start(2);
    wait_idle();

    scen = "R9 write on the accepting edge";
    @(negedge clk);
    start   = 1'b1;
    cycles  = 8'd2;
    freq_wr = 1'b1;
    freq_hz = 32'd2_500_000;
    @(negedge clk);
    start   = 1'b0;
    freq_wr = 1'b0;
    wait_idle();
    do_start(1);
    wait_idle();

    finish_run();
  end

endmodule